// File: doc/BRIEF.md
# I2C Paged Memory Controller

This block is an I2C target that fronts a 512-entry, 8-bit memory held in registers. It watches the bus clock and data lines (synchronized to the system clock), finds START and STOP conditions, and checks the leading byte of each transfer against a fixed four-bit type code. Bit 1 of that byte serves as address bit 8, and bit 0 chooses the direction. The block answers on the bus only by pulling data low, through an open-drain pull-down output.

A write transfer first loads the low eight address bits. It then collects up to sixteen data bytes into a page buffer that marks each byte it receives. The page is written to the array only at the STOP that closes the transfer, and only if the write-permit input is high at that moment. A timed write cycle of a parameterised number of system clocks follows, and during it the bus is ignored. A read transfer returns bytes from the address counter, most significant bit first. It keeps returning bytes as long as the master acknowledges each one.

Top module: `i2c_paged_mem`

## Requirements
- R1: After reset the pull-down output is inactive (0), and it stays inactive until the block is addressed.
- R2: A first byte whose bits [7:4] are not 1010 gets no acknowledge. The block then ignores every byte until the next START.
- R3: In the first byte, bits [3:2] are ignored, bit 1 is word address bit 8 and bit 0 chooses read (1) or write (0). A match is acknowledged on the ninth clock.
- R4: In a write, the second byte sets word address bits [7:0]. It and every following data byte are acknowledged. A single data byte followed by STOP stores that byte at the 9-bit address.
- R5: In a page write, address bits [3:0] increment after each data byte and wrap from 15 to 0, while bits [8:4] stay fixed. A 17th byte and later ones overwrite earlier bytes of the same page, and no other page is touched.
- R6: At commit only the page entries that received a byte are written. All other entries of the page keep their old contents.
- R7: A STOP that ends a write with buffered data starts a write cycle of WR_CYCLES clocks. During that cycle the block neither acknowledges nor drives the bus, even for a matching address.
- R8: If write-permit is low at that STOP, the buffered data is discarded, no write cycle starts, and the next matching address is acknowledged at once.
- R9: In a read, data bits change only while SCL is low, most significant bit first. After a master acknowledge the next byte follows, and the 9-bit address wraps from 0x1FF to 0x000. After a master no-acknowledge the bus is released until STOP.
- R10: A read with no word-address phase starts at the internal address counter. After a read, the counter points one past the last byte that was sent.
- R11: A START (including a repeated START) discards data that has been buffered but not committed. A following STOP without new data starts no write cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| wr_permit_i | input | 1 | High when the supply allows array writes |
| sda_pd_o | output | 1 | When 1, pull the bus data line low |

## Verification
The write cycle and a fresh bus transaction can overlap: a START and a matching address byte may arrive in the clocks right after the STOP that began a commit. The bench provokes this by sending a new START and address byte with no gap after a write STOP. It judges the outcome by the missing acknowledge, and later by reading back the committed byte. A second collision is a STOP that arrives with write-permit low. Here the bench sends a matching address at once and expects an acknowledge, then reads back the old contents.

// File: rtl/i2c_paged_mem.sv
module i2c_paged_mem #(
  parameter int WR_CYCLES = 2000,
  parameter int PW = 4,
  parameter int SYNC = 2,
  parameter logic [3:0] TYPE_ID = 4'b1010
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  input  logic wr_permit_i,
  output logic sda_pd_o
);
  localparam int AW = 9;
  localparam int DEPTH = 1 << AW;
  localparam int PAGE = 1 << PW;
  localparam int CW = $clog2(WR_CYCLES + 1);
  localparam logic [CW-1:0] WLAST = CW'(WR_CYCLES - 1);

  typedef enum logic [2:0] {S_IDLE, S_DEV, S_WA, S_WD, S_RD, S_IGN} st_t;

  logic [SYNC-1:0] scl_sy, sda_sy;
  logic scl_q, sda_q;
  logic scl_s, sda_s;
  st_t st;
  logic [3:0] bitc;
  logic [7:0] sh, tx;
  logic [AW-1:0] addr;
  logic ack, tx_en, mack, busy;
  logic [CW-1:0] wcnt;
  logic [PAGE-1:0] vld;
  logic [7:0] pbuf [PAGE];
  logic [7:0] mem [DEPTH];

  assign scl_s = scl_sy[SYNC-1];
  assign sda_s = sda_sy[SYNC-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sy <= '1;
      sda_sy <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_sy <= {scl_sy[SYNC-2:0], scl_i};
      sda_sy <= {sda_sy[SYNC-2:0], sda_i};
      scl_q  <= scl_s;
      sda_q  <= sda_s;
    end
  end

  wire start    = scl_s & scl_q & sda_q & ~sda_s;
  wire stop     = scl_s & scl_q & ~sda_q & sda_s;
  wire scl_rise = scl_s & ~scl_q;
  wire scl_fall = ~scl_s & scl_q;
  wire active   = (st != S_IDLE) && (st != S_IGN);
  wire wd_take  = !busy && !start && !stop && st == S_WD && scl_fall && bitc == 4'd8;
  wire commit   = busy && wcnt == WLAST;

  assign sda_pd_o = ack | (tx_en & ~tx[7]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      bitc  <= '0;
      sh    <= '0;
      tx    <= '0;
      addr  <= '0;
      ack   <= 1'b0;
      tx_en <= 1'b0;
      mack  <= 1'b0;
      busy  <= 1'b0;
      wcnt  <= '0;
      vld   <= '0;
    end else if (busy) begin
      st    <= S_IDLE;
      ack   <= 1'b0;
      tx_en <= 1'b0;
      if (commit) begin
        busy <= 1'b0;
        wcnt <= '0;
        vld  <= '0;
      end else begin
        wcnt <= wcnt + 1'b1;
      end
    end else if (start) begin
      st    <= S_DEV;
      bitc  <= '0;
      ack   <= 1'b0;
      tx_en <= 1'b0;
      vld   <= '0;
    end else if (stop) begin
      st    <= S_IDLE;
      ack   <= 1'b0;
      tx_en <= 1'b0;
      if (|vld && wr_permit_i) busy <= 1'b1;
      else vld <= '0;
    end else if (active) begin
      if (scl_rise) begin
        if (bitc == 4'd8) begin
          bitc <= '0;
          if (st == S_RD) mack <= ~sda_s;
        end else begin
          bitc <= bitc + 4'd1;
          sh   <= {sh[6:0], sda_s};
        end
      end else if (scl_fall) begin
        if (bitc == 4'd8) begin
          case (st)
            S_DEV: begin
              if (sh[7:4] == TYPE_ID) begin
                ack     <= 1'b1;
                addr[8] <= sh[1];
                if (sh[0]) begin
                  st   <= S_RD;
                  mack <= 1'b1;
                end else begin
                  st <= S_WA;
                end
              end else begin
                st <= S_IGN;
              end
            end
            S_WA: begin
              ack        <= 1'b1;
              addr[7:0]  <= sh;
              st         <= S_WD;
            end
            S_WD: begin
              ack                 <= 1'b1;
              vld[addr[PW-1:0]]   <= 1'b1;
              addr[PW-1:0]        <= addr[PW-1:0] + 1'b1;
            end
            S_RD: tx_en <= 1'b0;
            default: ;
          endcase
        end else if (bitc == 4'd0) begin
          ack <= 1'b0;
          if (st == S_RD) begin
            if (mack) begin
              tx    <= mem[addr];
              addr  <= addr + 1'b1;
              tx_en <= 1'b1;
            end else begin
              st    <= S_IGN;
              tx_en <= 1'b0;
            end
          end
        end else if (st == S_RD) begin
          tx <= {tx[6:0], 1'b0};
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (wd_take) pbuf[addr[PW-1:0]] <= sh;
    if (commit) begin
      for (int i = 0; i < PAGE; i++) begin
        if (vld[i]) mem[{addr[AW-1:PW], PW'(i)}] <= pbuf[i];
      end
    end
  end

  // R7
  busy_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n) busy |-> !sda_pd_o);
  // R7
  busy_count_chk: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> wcnt == '0);
  // R8
  permit_gate_chk: assert property (@(posedge clk) disable iff (!rst_n) $rose(busy) |-> $past(wr_permit_i));
  // R9
  sda_low_phase_chk: assert property (@(posedge clk) disable iff (!rst_n) !$stable(sda_pd_o) |-> !scl_s);
  // R6
  commit_clear_chk: assert property (@(posedge clk) disable iff (!rst_n) $fell(busy) |-> vld == '0);
  // R2
  ignore_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n) st == S_IGN |-> !sda_pd_o);
endmodule

// File: tb/test_i2c_paged_mem.sv
module test_i2c_paged_mem;
  localparam int WRC = 400;
  localparam int Q = 8;
  localparam logic [16:0] VEC [8] = '{
    {9'h000, 8'h11}, {9'h0FF, 8'h22}, {9'h100, 8'h33}, {9'h1FE, 8'h44},
    {9'h050, 8'h55}, {9'h130, 8'h66}, {9'h0A7, 8'h77}, {9'h011, 8'h88}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic wr_permit = 1'b1;
  logic sda_pd;
  logic bus;
  int n = 0;
  int fails = 0;
  logic [7:0] pg [16];

  assign bus = sda_m & ~sda_pd;
  always #4 clk = ~clk;

  i2c_paged_mem #(.WR_CYCLES(WRC)) i_i2c_paged_mem (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(bus),
    .wr_permit_i(wr_permit), .sda_pd_o(sda_pd)
  );

  task automatic q();
    repeat (Q) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic i2c_start();
    sda_m = 1'b1; q(); scl_m = 1'b1; q(); sda_m = 1'b0; q(); scl_m = 1'b0; q();
  endtask

  task automatic i2c_stop();
    sda_m = 1'b0; q(); scl_m = 1'b1; q(); sda_m = 1'b1; q();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ackd);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; q(); scl_m = 1'b1; q(); scl_m = 1'b0; q();
    end
    sda_m = 1'b1; q(); scl_m = 1'b1; q();
    ackd = ~bus;
    scl_m = 1'b0; q();
  endtask

  task automatic recv_byte(input logic mk, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      q(); scl_m = 1'b1; q(); b[i] = bus; scl_m = 1'b0;
    end
    q(); sda_m = ~mk; q(); scl_m = 1'b1; q(); scl_m = 1'b0; q(); sda_m = 1'b1;
  endtask

  task automatic wr_head(input logic [8:0] a, input logic [1:0] ign, input string req);
    logic k;
    i2c_start();
    send_byte({4'b1010, ign, a[8], 1'b0}, k);
    chk(req, k, 1'b1);
    send_byte(a[7:0], k);
    chk(req, k, 1'b1);
  endtask

  task automatic rd_head(input logic [8:0] a, input string req);
    logic k;
    wr_head(a, 2'b00, req);
    i2c_start();
    send_byte({4'b1010, 2'b00, a[8], 1'b1}, k);
    chk(req, k, 1'b1);
  endtask

  task automatic wait_wr();
    repeat (WRC + 50) @(negedge clk);
  endtask

  task automatic rd_one(input logic [8:0] a, output logic [7:0] d);
    rd_head(a, "R4 read setup");
    recv_byte(1'b0, d);
    i2c_stop();
  endtask

  initial begin
    repeat (190000) @(negedge clk);
    fails++;
    $display("FAIL watchdog act=running exp=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n, fails);
    $finish;
  end

  initial begin
    logic k;
    logic [7:0] d;
    repeat (5) @(negedge clk);
    chk("R1 pull-down during reset", sda_pd, 1'b0);
    rst_n = 1'b1;
    repeat (20) @(negedge clk);
    chk("R1 pull-down after reset", sda_pd, 1'b0);

    // R4 / R3: vector table, ignored bits varied, bank bit in addresses
    for (int i = 0; i < 8; i++) begin
      wr_head(VEC[i][16:8], 2'(i), "R3 R4 write acks");
      send_byte(VEC[i][7:0], k);
      chk("R4 data ack", k, 1'b1);
      i2c_stop();
      wait_wr();
    end
    for (int i = 0; i < 8; i++) begin
      rd_one(VEC[i][16:8], d);
      chk("R4 R3 readback", d, VEC[i][7:0]);
    end

    // R2: wrong type code
    i2c_start();
    send_byte(8'b1011_0000, k);
    chk("R2 mismatch no ack", k, 1'b0);
    send_byte(8'h00, k);
    chk("R2 ignored after mismatch", k, 1'b0);
    i2c_stop();

    // R5: 18-byte page write from 0x125
    wr_head(9'h125, 2'b01, "R5 page head");
    for (int i = 0; i < 18; i++) begin
      send_byte(8'hA0 + 8'(i), k);
      pg[(5 + i) % 16] = 8'hA0 + 8'(i);
    end
    i2c_stop();
    wait_wr();
    rd_head(9'h120, "R5 read head");
    for (int i = 0; i < 16; i++) begin
      recv_byte(i != 15, d);
      chk("R5 page wrap content", d, pg[i]);
    end
    i2c_stop();
    rd_one(9'h130, d);
    chk("R5 next page untouched", d, 8'h66);

    // R6: partial page write 0x12E..0x120
    wr_head(9'h12E, 2'b10, "R6 head");
    for (int i = 0; i < 3; i++) begin
      send_byte(8'hC0 + 8'(i), k);
      pg[(14 + i) % 16] = 8'hC0 + 8'(i);
    end
    i2c_stop();
    wait_wr();
    rd_head(9'h120, "R6 read head");
    for (int i = 0; i < 16; i++) begin
      recv_byte(i != 15, d);
      chk("R6 only received bytes written", d, pg[i]);
    end
    i2c_stop();

    // R7: address during write cycle
    wr_head(9'h0A7, 2'b00, "R7 head");
    send_byte(8'h78, k);
    i2c_stop();
    i2c_start();
    send_byte(8'b1010_0001, k);
    chk("R7 no ack while busy", k, 1'b0);
    i2c_stop();
    wait_wr();
    rd_one(9'h0A7, d);
    chk("R7 committed byte", d, 8'h78);

    // R8: permit low at STOP
    wr_permit = 1'b0;
    wr_head(9'h011, 2'b00, "R8 head");
    send_byte(8'hEE, k);
    i2c_stop();
    i2c_start();
    send_byte(8'b1010_0000, k);
    chk("R8 ack right after blocked stop", k, 1'b1);
    i2c_stop();
    wr_permit = 1'b1;
    rd_one(9'h011, d);
    chk("R8 data unchanged", d, 8'h88);

    // R11: repeated start discards buffered data
    wr_head(9'h050, 2'b00, "R11 head");
    send_byte(8'h99, k);
    wr_head(9'h050, 2'b00, "R11 restart");
    i2c_stop();
    i2c_start();
    send_byte(8'b1010_0000, k);
    chk("R11 no write cycle", k, 1'b1);
    i2c_stop();
    rd_one(9'h050, d);
    chk("R11 data unchanged", d, 8'h55);

    // R9: sequential read across 0x1FF -> 0x000, then NACK release
    wr_head(9'h1FF, 2'b00, "R9 head");
    send_byte(8'hA5, k);
    i2c_stop();
    wait_wr();
    wr_head(9'h000, 2'b00, "R9 head2");
    send_byte(8'h5A, k);
    send_byte(8'h77, k);
    i2c_stop();
    wait_wr();
    rd_head(9'h1FF, "R9 read head");
    recv_byte(1'b1, d);
    chk("R9 byte at 0x1FF", d, 8'hA5);
    recv_byte(1'b0, d);
    chk("R9 wrapped to 0x000", d, 8'h5A);
    recv_byte(1'b0, d);
    chk("R9 released after nack", d, 8'hFF);
    i2c_stop();

    // R10: current-address read
    i2c_start();
    send_byte(8'b1010_0001, k);
    chk("R10 ack", k, 1'b1);
    recv_byte(1'b0, d);
    chk("R10 counter continues", d, 8'h77);
    i2c_stop();
    repeat (20) @(negedge clk);
    chk("R1 idle release", sda_pd, 1'b0);

    $display("== %0d vectors applied, %0d miscompares ==", n, fails);
    $finish;
  end
endmodule